// File: doc/BRIEF.md
# Binary Field Arithmetic Command Engine

This block performs arithmetic on elements of GF(2^m), where each value is a bit string whose bits are the coefficients of a polynomial over GF(2). It holds four operand registers (numbered 0 to 3) and one modulus register. A command names an operation, a target register and up to two source registers, and any of them may be any of the four operands. Four operations are supported: clear, copy, add and multiply. Add is a bitwise XOR. Multiply computes the product reduced modulo the polynomial held in the modulus register.

Software or a sequencer loads operands and the modulus one word at a time and then issues a command. It waits for the one-cycle done pulse and reads results back one word at a time. Each word read back also updates a status output. That status holds the bit position of the highest set bit in the word, or a zero flag when the word is empty. The multiplier is digit-serial and handles DIGIT coefficient bits of the second source per cycle. The field size, the digit depth and the word width are parameters.

Top module: `gf2m_engine`

## Requirements
- R1: After reset every operand register reads as zero, the modulus reads as x^FIELD_M + 1, busy and done are low, and the status shows position 0 with the zero flag set.
- R2: A cmd_start seen while busy is low is accepted at that clock edge. busy is then high from the next cycle up to and including the done cycle. done is high for exactly one cycle, and a cmd_start seen while busy is high has no effect.
- R3: Opcode 0 (clear) writes zero into the target over its full length, and busy lasts 1 cycle.
- R4: Opcode 1 (copy) writes source 0 into the target, and busy lasts 1 cycle.
- R5: Opcode 2 (add) writes the bitwise XOR of source 0 and source 1 into the target, and busy lasts 3 cycles.
- R6: Opcode 3 (multiply) writes source 0 times source 1, reduced modulo the modulus polynomial, into the target. busy lasts 2 + ceil(FIELD_M/DIGIT) cycles.
- R7: The target may equal either source or both. Sources are captured when the command is accepted, so the result is the one computed from the values held before the command.
- R8: Clear, copy and add give the same results whatever the modulus register holds.
- R9: wr_sel 0 to 3 selects an operand register and 4 selects the modulus. wr_idx selects the word, with word 0 holding the lowest bits. Operand bits at FIELD_M and above are stored as zero. Modulus bits above FIELD_M are stored as zero and bit FIELD_M is always stored as one. Writes while busy is high are ignored.
- R10: The cycle after rd_en, rd_data holds the selected word of the selected register, using the same selection codes as writes. Selection codes 5 to 7 read as zero.
- R11: Together with each readback word, stat_msb gives the position of that word's most significant 1 and stat_zero is low. For an all-zero word, stat_msb is 0 and stat_zero is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Command request |
| cmd_op | input | 2 | Opcode: 0 clear, 1 copy, 2 add, 3 multiply |
| cmd_tgt | input | 2 | Target operand register |
| cmd_src0 | input | 2 | First source operand register |
| cmd_src1 | input | 2 | Second source operand register |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse in the cycle the result is written |
| wr_en | input | 1 | Word load strobe |
| wr_sel | input | 3 | Load register select (0-3 operand, 4 modulus) |
| wr_idx | input | IDX_W | Load word index |
| wr_data | input | WORD_W | Load data |
| rd_en | input | 1 | Readback strobe |
| rd_sel | input | 3 | Readback register select |
| rd_idx | input | IDX_W | Readback word index |
| rd_data | output | WORD_W | Readback word, valid the cycle after rd_en |
| stat_msb | output | POS_W | Highest set bit position of the last readback word |
| stat_zero | output | 1 | Last readback word was all zero |

## Verification
The bench targets the reduction path with the product x * x^(m-1), which lands exactly on x^m. A multiplier that drops or misplaces the modulus fold would return x^m itself, truncated to zero, instead of the low terms of the modulus. Aliased commands, such as squaring a register into itself, catch a design that reads a source after a partial write. A command or a load issued while busy would show up as a cleared or overwritten register. Readback of words with only bit 31, only bit 0 or no bits set exposes off-by-one errors and an undefined status for an empty word.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;
    typedef enum logic [1:0] {
        OP_CLR  = 2'd0,
        OP_COPY = 2'd1,
        OP_ADD  = 2'd2,
        OP_MUL  = 2'd3
    } gf_op_e;

    localparam logic [2:0] SEL_MOD = 3'd4;
endpackage

// File: rtl/gf2m_digit_step.sv
module gf2m_digit_step #(
    parameter int FIELD_M = 61,
    parameter int DIGIT   = 4
) (
    input  logic [FIELD_M-1:0] acc_in,
    input  logic [FIELD_M-1:0] a_in,
    input  logic [FIELD_M:0]   poly,
    input  logic [DIGIT-1:0]   dig,
    output logic [FIELD_M-1:0] acc_out
);
    // Most-significant digit bit first: acc = acc*x mod p, then add a if bit set.
    logic [FIELD_M-1:0] stage [0:DIGIT];

    assign stage[0] = acc_in;

    for (genvar j = 0; j < DIGIT; j++) begin : g_bit
        logic [FIELD_M:0] shifted;
        logic [FIELD_M:0] folded;
        assign shifted = {stage[j], 1'b0};
        assign folded  = shifted[FIELD_M] ? (shifted ^ poly) : shifted;
        assign stage[j+1] = folded[FIELD_M-1:0] ^ (dig[DIGIT-1-j] ? a_in : '0);
    end

    assign acc_out = stage[DIGIT];
endmodule

// File: rtl/gf2m_msb_find.sv
module gf2m_msb_find #(
    parameter int WORD_W = 32,
    localparam int POS_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word,
    output logic [POS_W-1:0]  pos,
    output logic              is_zero
);
    always_comb begin
        pos     = '0;
        is_zero = 1'b1;
        for (int i = 0; i < WORD_W; i++) begin
            if (word[i]) begin
                pos     = POS_W'(i);
                is_zero = 1'b0;
            end
        end
    end
endmodule

// File: rtl/gf2m_engine.sv
module gf2m_engine
    import gf2m_pkg::*;
#(
    parameter int FIELD_M = 61,
    parameter int DIGIT   = 4,
    parameter int WORD_W  = 32,
    localparam int NWORDS = (FIELD_M + WORD_W) / WORD_W,
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int POS_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic [1:0]        cmd_tgt,
    input  logic [1:0]        cmd_src0,
    input  logic [1:0]        cmd_src1,
    output logic              busy,
    output logic              done,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_sel,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic [POS_W-1:0]  stat_msb,
    output logic              stat_zero
);
    localparam int REG_W   = NWORDS * WORD_W;
    localparam int NDIG    = (FIELD_M + DIGIT - 1) / DIGIT;
    localparam int PAD_W   = NDIG * DIGIT;
    localparam int LAT_MUL = 2 + NDIG;
    localparam int CNT_W   = $clog2(LAT_MUL) + 1;

    localparam logic [REG_W-1:0] OP_MASK  = {{(REG_W-FIELD_M){1'b0}}, {FIELD_M{1'b1}}};
    localparam logic [REG_W-1:0] MOD_MASK = {{(REG_W-FIELD_M-1){1'b0}}, {(FIELD_M+1){1'b1}}};
    localparam logic [REG_W-1:0] MOD_TOP  = REG_W'(1) << FIELD_M;

    typedef struct packed {
        logic                  busy;
        gf_op_e                op;
        logic [1:0]            tgt;
        logic [CNT_W-1:0]      cnt;
        logic [FIELD_M-1:0]    opa;
        logic [FIELD_M-1:0]    opb;
        logic [FIELD_M-1:0]    acc;
        logic [3:0][REG_W-1:0] regs;
        logic [REG_W-1:0]      modp;
        logic [WORD_W-1:0]     rdw;
        logic [POS_W-1:0]      msb;
        logic                  zero;
    } state_t;

    state_t s_d, s_q;

    // Digit selection for the multiplier, most significant digit first.
    logic [PAD_W-1:0]   bpad;
    logic [DIGIT-1:0]   dig;
    logic [FIELD_M-1:0] step_out;
    logic               in_digit;

    always_comb begin
        int didx;
        bpad     = PAD_W'(s_q.opb);
        in_digit = (s_q.cnt != '0) && (s_q.cnt <= CNT_W'(NDIG));
        didx     = in_digit ? (int'(s_q.cnt) - 1) : 0;
        dig      = bpad[didx*DIGIT +: DIGIT];
    end

    gf2m_digit_step #(
        .FIELD_M (FIELD_M),
        .DIGIT   (DIGIT)
    ) u_step (
        .acc_in  (s_q.acc),
        .a_in    (s_q.opa),
        .poly    (s_q.modp[FIELD_M:0]),
        .dig     (dig),
        .acc_out (step_out)
    );

    // Readback word selection and degree detection.
    logic [WORD_W-1:0] rd_word;
    logic [POS_W-1:0]  rd_pos;
    logic              rd_zero;

    always_comb begin
        int ridx;
        ridx    = int'(rd_idx);
        rd_word = '0;
        if (ridx < NWORDS) begin
            if (rd_sel < SEL_MOD)
                rd_word = s_q.regs[rd_sel[1:0]][ridx*WORD_W +: WORD_W];
            else if (rd_sel == SEL_MOD)
                rd_word = s_q.modp[ridx*WORD_W +: WORD_W];
        end
    end

    gf2m_msb_find #(
        .WORD_W (WORD_W)
    ) u_msb (
        .word    (rd_word),
        .pos     (rd_pos),
        .is_zero (rd_zero)
    );

    logic done_w;
    assign done_w = s_q.busy && (s_q.cnt == '0);

    always_comb begin
        logic [REG_W-1:0] wtmp;
        logic [REG_W-1:0] result;
        int widx;
        s_d    = s_q;
        wtmp   = '0;
        result = '0;
        widx   = int'(wr_idx);

        // Word loads, blocked while a command runs.
        if (wr_en && !s_q.busy && widx < NWORDS) begin
            if (wr_sel < SEL_MOD) begin
                wtmp = s_q.regs[wr_sel[1:0]];
                wtmp[widx*WORD_W +: WORD_W] = wr_data;
                s_d.regs[wr_sel[1:0]] = wtmp & OP_MASK;
            end else if (wr_sel == SEL_MOD) begin
                wtmp = s_q.modp;
                wtmp[widx*WORD_W +: WORD_W] = wr_data;
                s_d.modp = (wtmp & MOD_MASK) | MOD_TOP;
            end
        end

        // Command acceptance captures both sources.
        if (cmd_start && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.op   = gf_op_e'(cmd_op);
            s_d.tgt  = cmd_tgt;
            s_d.opa  = s_q.regs[cmd_src0][FIELD_M-1:0];
            s_d.opb  = s_q.regs[cmd_src1][FIELD_M-1:0];
            s_d.acc  = '0;
            unique case (gf_op_e'(cmd_op))
                OP_CLR:  s_d.cnt = '0;
                OP_COPY: s_d.cnt = '0;
                OP_ADD:  s_d.cnt = CNT_W'(2);
                OP_MUL:  s_d.cnt = CNT_W'(LAT_MUL - 1);
                default: s_d.cnt = '0;
            endcase
        end else if (s_q.busy) begin
            if (s_q.cnt != '0) begin
                s_d.cnt = s_q.cnt - 1'b1;
                if (s_q.op == OP_MUL && in_digit)
                    s_d.acc = step_out;
            end else begin
                unique case (s_q.op)
                    OP_CLR:  result = '0;
                    OP_COPY: result = REG_W'(s_q.opa);
                    OP_ADD:  result = REG_W'(s_q.opa ^ s_q.opb);
                    OP_MUL:  result = REG_W'(s_q.acc);
                    default: result = '0;
                endcase
                s_d.regs[s_q.tgt] = result;
                s_d.busy = 1'b0;
            end
        end

        // Readback with implicit degree status.
        if (rd_en) begin
            s_d.rdw  = rd_word;
            s_d.msb  = rd_pos;
            s_d.zero = rd_zero;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.op   <= OP_CLR;
            s_q.modp <= MOD_TOP | REG_W'(1);
            s_q.zero <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.busy;
    assign done      = done_w;
    assign rd_data   = s_q.rdw;
    assign stat_msb  = s_q.msb;
    assign stat_zero = s_q.zero;

    // Assertions next to the control and status logic.
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_ends_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));
    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy) |=> busy);
    assert_regs_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(s_q.regs));
    assert_mod_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.modp[FIELD_M] && ((s_q.modp & ~MOD_MASK) == '0));
    assert_status_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_zero == (rd_data == '0));
    assert_status_msb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_zero |-> ((rd_data >> stat_msb) == WORD_W'(1)));
endmodule

// File: tb/sim_gf2m_engine.sv
`timescale 1ns/1ps
module sim_gf2m_engine;
    localparam int M     = 61;
    localparam int D     = 4;
    localparam int MULC  = 2 + (M + D - 1) / D;
    localparam logic [63:0] OPM  = (64'd1 << M) - 64'd1;
    localparam logic [63:0] TOPB = 64'd1 << M;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        cmd_start = 0;
    logic [1:0]  cmd_op = 0, cmd_tgt = 0, cmd_src0 = 0, cmd_src1 = 0;
    logic        busy, done;
    logic        wr_en = 0;
    logic [2:0]  wr_sel = 0;
    logic [0:0]  wr_idx = 0;
    logic [31:0] wr_data = 0;
    logic        rd_en = 0;
    logic [2:0]  rd_sel = 0;
    logic [0:0]  rd_idx = 0;
    logic [31:0] rd_data;
    logic [4:0]  stat_msb;
    logic        stat_zero;

    gf2m_engine #(.FIELD_M(M), .DIGIT(D), .WORD_W(32)) u0 (
        .clk, .rst_n, .cmd_start, .cmd_op, .cmd_tgt, .cmd_src0, .cmd_src1,
        .busy, .done, .wr_en, .wr_sel, .wr_idx, .wr_data,
        .rd_en, .rd_sel, .rd_idx, .rd_data, .stat_msb, .stat_zero
    );

    int checks = 0;
    int fails  = 0;
    logic [63:0] mdl [0:3];
    logic [63:0] mdl_p;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic int msb_of(input logic [31:0] w);
        int p = 0;
        for (int i = 0; i < 32; i++) if (w[i]) p = i;
        return p;
    endfunction

    function automatic logic [63:0] mul_ref(input logic [63:0] a, input logic [63:0] b, input logic [63:0] p);
        logic [127:0] prod = '0;
        for (int i = 0; i < M; i++) if (b[i]) prod ^= ({64'd0, a} << i);
        for (int i = 2*M-2; i >= M; i--) if (prod[i]) prod ^= ({64'd0, p} << (i - M));
        return prod[63:0];
    endfunction

    task automatic write_word(input logic [2:0] sel, input bit idx, input logic [31:0] w);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_idx = idx; wr_data = w;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic write_full(input logic [2:0] sel, input logic [63:0] v);
        write_word(sel, 1'b0, v[31:0]);
        write_word(sel, 1'b1, v[63:32]);
        if (sel < 4) mdl[sel[1:0]] = v & OPM;
        else if (sel == 4) mdl_p = (v & (OPM | TOPB)) | TOPB;
    endtask

    task automatic read_word(input logic [2:0] sel, input bit idx, output logic [31:0] w);
        @(negedge clk);
        rd_en = 1; rd_sel = sel; rd_idx = idx;
        @(negedge clk);
        rd_en = 0;
        w = rd_data;
        // R11: degree status travels with the word
        chk(stat_zero == (w == 0), "R11 zero flag", {63'd0, stat_zero}, {63'd0, w == 0});
        chk(stat_msb == ((w == 0) ? 5'd0 : 5'(msb_of(w))), "R11 msb position",
            {59'd0, stat_msb}, (w == 0) ? 64'd0 : 64'(msb_of(w)));
    endtask

    task automatic read_full(input logic [2:0] sel, output logic [63:0] v);
        logic [31:0] lo, hi;
        read_word(sel, 1'b0, lo);
        read_word(sel, 1'b1, hi);
        v = {hi, lo};
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [1:0] t, input logic [1:0] s0,
                           input logic [1:0] s1, input bit interfere, input string tag);
        int cyc;
        int expc;
        logic [63:0] a, b, r;
        a = mdl[s0]; b = mdl[s1];
        case (op)
            2'd0: begin r = 64'd0;           expc = 1;    end
            2'd1: begin r = a;               expc = 1;    end
            2'd2: begin r = a ^ b;           expc = 3;    end
            default: begin r = mul_ref(a, b, mdl_p); expc = MULC; end
        endcase
        @(negedge clk);
        cmd_start = 1; cmd_op = op; cmd_tgt = t; cmd_src0 = s0; cmd_src1 = s1;
        @(negedge clk);
        cmd_start = 0;
        chk(busy == 1'b1, {tag, " R2 busy after accept"}, {63'd0, busy}, 64'd1);
        cyc = 1;
        while (!done && cyc < 100) begin
            if (interfere && cyc == 1) begin
                cmd_start = 1; cmd_op = 2'd0; cmd_tgt = s0;
                wr_en = 1; wr_sel = {1'b0, s1}; wr_idx = 0; wr_data = 32'hFFFF_FFFF;
            end
            @(negedge clk);
            cmd_start = 0; wr_en = 0;
            cyc++;
        end
        chk(cyc == expc, {tag, " latency"}, 64'(cyc), 64'(expc));
        @(negedge clk);
        chk(!done && !busy, {tag, " R2 done single pulse, idle after"}, {62'd0, done, busy}, 64'd0);
        mdl[t] = r;
    endtask

    task automatic check_all(input string tag);
        logic [63:0] v;
        for (int k = 0; k < 4; k++) begin
            read_full(3'(k), v);
            chk(v == mdl[k], tag, v, mdl[k]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        logic [63:0] v;
        logic [31:0] w;
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < 4; k++) mdl[k] = 64'd0;
        mdl_p = TOPB | 64'd1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk(!busy && !done, "R1 busy/done low", {62'd0, busy, done}, 64'd0);
        chk(stat_zero && stat_msb == 0, "R1 status", {58'd0, stat_zero, stat_msb}, 64'h20);
        check_all("R1 operand reset zero");
        read_full(3'd4, v);
        chk(v == (TOPB | 64'd1), "R1 modulus reset", v, TOPB | 64'd1);

        // R9: masking on load
        write_full(3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        read_full(3'd0, v);
        chk(v == OPM, "R9 operand upper bits dropped", v, OPM);
        write_full(3'd4, 64'hC000_0000_0000_0027);
        read_full(3'd4, v);
        chk(v == (TOPB | 64'h27), "R9 modulus top forced", v, TOPB | 64'h27);

        // R10: unused selects read zero
        read_word(3'd5, 1'b0, w);
        chk(w == 0, "R10 unused select", {32'd0, w}, 64'd0);

        // R11: degree boundary words
        write_full(3'd1, 64'h0000_0001_8000_0000);
        read_word(3'd1, 1'b0, w);
        chk(stat_msb == 5'd31, "R11 bit 31", {59'd0, stat_msb}, 64'd31);
        read_word(3'd1, 1'b1, w);
        chk(stat_msb == 5'd0 && !stat_zero, "R11 bit 0", {58'd0, stat_zero, stat_msb}, 64'd0);

        // R6: x * x^(M-1) folds onto the modulus low terms
        write_full(3'd0, 64'd2);
        write_full(3'd1, 64'd1 << (M - 1));
        run_cmd(2'd3, 2'd2, 2'd0, 2'd1, 1'b0, "R6 mul fold");
        read_full(3'd2, v);
        chk(v == 64'h27, "R6 x*x^(m-1) result", v, 64'h27);

        // R2/R9: command and write while busy are ignored
        write_full(3'd0, 64'h0123_4567_89AB_CDEF);
        write_full(3'd1, 64'h0FED_CBA9_8765_4321);
        run_cmd(2'd3, 2'd3, 2'd0, 2'd1, 1'b1, "R2 mul with interference");
        check_all("R2 R9 ignored while busy");

        // R7: aliasing, square in place
        run_cmd(2'd3, 2'd0, 2'd0, 2'd0, 1'b0, "R7 square alias");
        run_cmd(2'd2, 2'd1, 2'd1, 2'd1, 1'b0, "R7 add self alias");
        check_all("R7 alias results");

        // R3/R4/R5/R8: non-mul ops with two moduli
        write_full(3'd0, 64'h1111_2222_3333_4444);
        write_full(3'd1, 64'h0A0A_0B0B_0C0C_0D0D);
        run_cmd(2'd2, 2'd2, 2'd0, 2'd1, 1'b0, "R5 add");
        run_cmd(2'd1, 2'd3, 2'd0, 2'd0, 1'b0, "R4 copy");
        check_all("R8 results with modulus A");
        write_full(3'd4, 64'hFFFF_FFFF_FFFF_FFFF);
        run_cmd(2'd2, 2'd2, 2'd0, 2'd1, 1'b0, "R8 add");
        run_cmd(2'd1, 2'd3, 2'd1, 2'd1, 1'b0, "R8 copy");
        run_cmd(2'd0, 2'd1, 2'd0, 2'd0, 1'b0, "R3 clear");
        check_all("R3 R4 R5 R8 results with modulus B");

        // Random mix
        for (int it = 0; it < 50; it++) begin
            if (it % 10 == 0) write_full(3'd4, {$urandom, $urandom});
            if (it % 4 == 0) write_full(3'($urandom_range(0, 3)), {$urandom, $urandom});
            run_cmd(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                    2'($urandom_range(0, 3)), 1'b0, "R3 R4 R5 R6 random");
            check_all("R6 R7 random readback");
        end

        finish_run();
    end
endmodule